// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Acknowledge Unit

This block joins two eight-line interrupt cores, one primary and one secondary, into a sixteen-line interrupt system with one processor request pin. Primary lines 0 to 7 arrive on `irq_lines[7:0]` and secondary lines 0 to 7 on `irq_lines[15:8]`. Primary line 2 has no external source. It is fed from the secondary core: each cycle in which the secondary holds a valid request, a set pulse is applied to primary line 2, so the cascade always looks like a new edge to the primary.

Each core latches rising edges into a pending set and tracks an in-service set. A core picks its lowest-numbered pending line that is not masked. That line counts as a valid request only when it outranks every line in service. A one-cycle acknowledge strobe from the processor chooses the core that supplies the vector. When the primary winner is a normal line, the primary vector is produced. When the primary winner is line 2, the secondary vector is produced. A core with nothing valid produces a spurious vector on line 7. A non-specific end-of-interrupt strobe on each core retires that core's highest-priority in-service line.

The vector leaves on a valid-only output with no back-pressure. The registered vector and `vec_valid` change only in the cycle after an acknowledge. The consumer cannot stall the vector, and the vector stays unchanged until the next acknowledge.

Top module: `cascade_ack_unit`

## Requirements
- R1: During and after reset, `cpu_irq`, `vec_valid` and `vec` are all 0.
- R2: A rising edge on an unmasked primary line n (n not 2) raises `cpu_irq`. An acknowledge then gives `vec = {mst_base[7:3], n}` with `vec_valid = 1` in the following cycle.
- R3: Among pending lines, the lowest number wins. An in-service line blocks requests on its own line and on higher-numbered lines of the same core. A non-specific end-of-interrupt clears the lowest-numbered in-service bit of its core.
- R4: A secondary line k reaches `cpu_irq` through primary line 2. The acknowledge gives `{slv_base[7:3], k}` and puts primary line 2 and secondary line k in service.
- R5: An acknowledge while the primary has no valid request gives `{mst_base[7:3], 3'd7}` and changes no core state.
- R6: An acknowledge that selects primary line 2 while the secondary has no valid request gives `{slv_base[7:3], 3'd7}`.
- R7: Bits 2:0 of `mst_base` and `slv_base` never reach `vec`.
- R8: `irq_lines[2]` has no effect.
- R9: Requests are edge-triggered. A line held high requests only once until it goes low and high again.
- R10: A masked line does not reach `cpu_irq`, but its pending bit is kept and takes effect when the mask bit clears.
- R11: `vec` and `vec_valid` hold their values in every cycle without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines. Bits 7:0 go to the primary core, bits 15:8 to the secondary core. Bit 2 is unused. |
| line_mask | input | 16 | Per-line mask, 1 = masked. Bit 2 masks the cascade. |
| mst_base | input | 8 | Primary vector base. Only bits 7:3 are used. |
| slv_base | input | 8 | Secondary vector base. Only bits 7:3 are used. |
| inta | input | 1 | One-cycle acknowledge strobe |
| eoi_mst | input | 1 | Non-specific end-of-interrupt for the primary core |
| eoi_slv | input | 1 | Non-specific end-of-interrupt for the secondary core |
| cpu_irq | output | 1 | Processor interrupt request, which is the primary core's valid request |
| vec_valid | output | 1 | Vector valid. Set by the first acknowledge and then held. |
| vec | output | 8 | Vector from the last acknowledge |

## Verification
A wrong in-service bit shows at `cpu_irq` in the same cycle. Either a request that should be blocked gets through, or a pending line stays hidden until the next end-of-interrupt. A lost or stray pending bit, including a stale cascade bit on primary line 2, shows in the vector of the next acknowledge. A wrong routing choice shows as a wrong vector one cycle after the strobe.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int unsigned CORE_LINES = 8;
  localparam int unsigned LINE_W     = $clog2(CORE_LINES);
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned BASE_KEEP  = VEC_W - LINE_W;
  localparam int unsigned CASC_LINE  = 2;
  localparam int unsigned SPUR_LINE  = CORE_LINES - 1;
  typedef logic [LINE_W-1:0] line_idx_t;
  typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/cascade_prio.sv
module cascade_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/cascade_core.sv
module cascade_core #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_in,
  input  logic [N-1:0] pulse_in,
  input  logic [N-1:0] mask,
  input  logic         ack,
  input  logic         eoi,
  output logic         pend,
  output logic [W-1:0] win
);
  logic [N-1:0] last_q, irr_q, isr_q;
  logic [N-1:0] req_set, ack_clr, eoi_clr;
  logic         rq_found, is_found;
  logic [W-1:0] rq_idx, is_idx;

  cascade_prio #(.N(N)) u_req (.bits(irr_q & ~mask), .found(rq_found), .idx(rq_idx));
  cascade_prio #(.N(N)) u_svc (.bits(isr_q), .found(is_found), .idx(is_idx));

  always_comb begin
    req_set = (edge_in & ~last_q) | pulse_in;
    pend    = rq_found && (!is_found || (rq_idx < is_idx));
    win     = rq_idx;
    ack_clr = (ack && pend) ? ({{(N-1){1'b0}}, 1'b1} << rq_idx) : '0;
    eoi_clr = (eoi && is_found) ? ({{(N-1){1'b0}}, 1'b1} << is_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      last_q <= edge_in;
      irr_q  <= (irr_q & ~ack_clr) | req_set;
      isr_q  <= (isr_q & ~eoi_clr) | ack_clr;
    end
  end

  // R3
  ack_marks_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend) |=> isr_q[$past(win)]);

  // R3
  nested_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ((isr_q & ((N'(1) << win) | ((N'(1) << win) - N'(1)))) == '0));

  // R10
  mask_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mask[win]);
endmodule

// File: rtl/cascade_vec_sel.sv
module cascade_vec_sel
  import cascade_pkg::*;
(
  input  logic      mst_pend,
  input  line_idx_t mst_win,
  input  logic      slv_pend,
  input  line_idx_t slv_win,
  input  vec_t      mst_base,
  input  vec_t      slv_base,
  output logic      to_slave,
  output vec_t      vec_next
);
  always_comb begin
    to_slave = mst_pend && (mst_win == line_idx_t'(CASC_LINE));
    if (!mst_pend)
      vec_next = {mst_base[VEC_W-1:LINE_W], line_idx_t'(SPUR_LINE)};
    else if (!to_slave)
      vec_next = {mst_base[VEC_W-1:LINE_W], mst_win};
    else if (slv_pend)
      vec_next = {slv_base[VEC_W-1:LINE_W], slv_win};
    else
      vec_next = {slv_base[VEC_W-1:LINE_W], line_idx_t'(SPUR_LINE)};
  end
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit
  import cascade_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic [15:0] line_mask,
  input  logic [7:0]  mst_base,
  input  logic [7:0]  slv_base,
  input  logic        inta,
  input  logic        eoi_mst,
  input  logic        eoi_slv,
  output logic        cpu_irq,
  output logic        vec_valid,
  output logic [7:0]  vec
);
  localparam int unsigned L = CORE_LINES;

  logic [L-1:0] m_edge, m_pulse;
  logic         m_pend, s_pend, s_ack, to_slave;
  line_idx_t    m_win, s_win;
  vec_t         vec_next, vec_q;
  logic         vld_q;

  for (genvar i = 0; i < L; i++) begin : g_mline
    if (i == CASC_LINE) begin : g_casc
      assign m_edge[i]  = 1'b0;
      assign m_pulse[i] = s_pend && !s_ack;
    end else begin : g_plain
      assign m_edge[i]  = irq_lines[i];
      assign m_pulse[i] = 1'b0;
    end
  end

  cascade_core #(.N(L)) u_mst (
    .clk(clk), .rst_n(rst_n), .edge_in(m_edge), .pulse_in(m_pulse),
    .mask(line_mask[L-1:0]), .ack(inta), .eoi(eoi_mst),
    .pend(m_pend), .win(m_win));

  cascade_core #(.N(L)) u_slv (
    .clk(clk), .rst_n(rst_n), .edge_in(irq_lines[2*L-1:L]), .pulse_in('0),
    .mask(line_mask[2*L-1:L]), .ack(s_ack), .eoi(eoi_slv),
    .pend(s_pend), .win(s_win));

  cascade_vec_sel u_sel (
    .mst_pend(m_pend), .mst_win(m_win), .slv_pend(s_pend), .slv_win(s_win),
    .mst_base(mst_base), .slv_base(slv_base), .to_slave(to_slave),
    .vec_next(vec_next));

  assign s_ack = inta && to_slave;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else if (inta) begin
      vec_q <= vec_next;
      vld_q <= 1'b1;
    end
  end

  assign cpu_irq   = m_pend;
  assign vec       = vec_q;
  assign vec_valid = vld_q;

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> ($stable(vec) && $stable(vec_valid)));

  // R2
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);

  // R5
  spur_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !cpu_irq) |=> (vec == {$past(mst_base[7:3]), 3'd7}));

  // R7
  base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && cpu_irq && !to_slave) |=> (vec[7:3] == $past(mst_base[7:3])));
endmodule

// File: tb/tb_cascade_ack_unit.sv
module tb_cascade_ack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [15:0] line_mask = '0;
  logic [7:0]  mst_base = 8'h25;
  logic [7:0]  slv_base = 8'h7B;
  logic        inta = 1'b0, eoi_mst = 1'b0, eoi_slv = 1'b0;
  logic        cpu_irq, vec_valid;
  logic [7:0]  vec;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cascade_ack_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .line_mask(line_mask),
    .mst_base(mst_base), .slv_base(slv_base), .inta(inta),
    .eoi_mst(eoi_mst), .eoi_slv(eoi_slv), .cpu_irq(cpu_irq),
    .vec_valid(vec_valid), .vec(vec));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(logic [7:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    cyc(1);
  endtask

  task automatic eoi(bit slv);
    if (slv) eoi_slv = 1'b1; else eoi_mst = 1'b1;
    @(negedge clk);
    eoi_slv = 1'b0;
    eoi_mst = 1'b0;
    cyc(1);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (inta && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected vector actual=%0h expected=none", vec);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, vec, e);
          check({t, " valid"}, {7'd0, vec_valid}, 8'd1);
        end
      end
    end
  end

  initial begin
    int n;
    n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<=20000", n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    check("R1 cpu_irq", {7'd0, cpu_irq}, 8'd0);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    check("R1 vec", vec, 8'h00);
    rst_n = 1'b1;
    cyc(1);

    do_ack(8'h27, "R5 primary spurious");
    check("R5 no state change", {7'd0, cpu_irq}, 8'd0);

    irq_lines[2] = 1'b1; cyc(4);
    check("R8 line 2 ignored", {7'd0, cpu_irq}, 8'd0);
    irq_lines[2] = 1'b0;

    irq_lines[5] = 1'b1; cyc(2);
    check("R2 irq raised", {7'd0, cpu_irq}, 8'd1);
    do_ack(8'h25, "R2 R7 primary line 5");
    check("R3 in service drops irq", {7'd0, cpu_irq}, 8'd0);
    cyc(5);
    check("R11 vec held", vec, 8'h25);
    check("R11 valid held", {7'd0, vec_valid}, 8'd1);
    eoi(1'b0);
    check("R9 held line no rerequest", {7'd0, cpu_irq}, 8'd0);
    irq_lines[5] = 1'b0;

    irq_lines[6] = 1'b1; irq_lines[3] = 1'b1; cyc(2);
    do_ack(8'h23, "R3 lowest wins");
    check("R3 line 6 blocked", {7'd0, cpu_irq}, 8'd0);
    irq_lines[1] = 1'b1; cyc(2);
    check("R3 higher preempts", {7'd0, cpu_irq}, 8'd1);
    do_ack(8'h21, "R3 nested line 1");
    eoi(1'b0);
    check("R3 eoi clears only line 1", {7'd0, cpu_irq}, 8'd0);
    eoi(1'b0);
    check("R3 line 6 released", {7'd0, cpu_irq}, 8'd1);
    do_ack(8'h26, "R3 line 6");
    eoi(1'b0);
    irq_lines = '0;
    cyc(2);

    irq_lines[12] = 1'b1; cyc(4);
    check("R4 slave raises irq", {7'd0, cpu_irq}, 8'd1);
    do_ack(8'h7C, "R4 slave line 4");
    irq_lines[4] = 1'b1; irq_lines[9] = 1'b1; cyc(4);
    check("R4 primary line 2 in service blocks", {7'd0, cpu_irq}, 8'd0);
    eoi(1'b0);
    cyc(1);
    check("R4 slave line 1 after eoi", {7'd0, cpu_irq}, 8'd1);
    do_ack(8'h79, "R4 slave line 1");
    eoi(1'b1); eoi(1'b1); eoi(1'b0);
    cyc(1);
    do_ack(8'h24, "R4 primary line 4 after cascade");
    eoi(1'b0);
    irq_lines = '0;
    cyc(2);
    check("R4 idle", {7'd0, cpu_irq}, 8'd0);

    irq_lines[8] = 1'b1; cyc(4);
    line_mask[8] = 1'b1; cyc(1);
    do_ack(8'h7F, "R6 slave spurious");
    line_mask[8] = 1'b0; cyc(3);
    check("R10 unmasked but primary 2 in service", {7'd0, cpu_irq}, 8'd0);
    eoi(1'b0);
    cyc(2);
    do_ack(8'h78, "R10 retained slave line 0");
    eoi(1'b1); eoi(1'b0);
    irq_lines = '0;

    line_mask[0] = 1'b1; irq_lines[0] = 1'b1; cyc(3);
    check("R10 masked", {7'd0, cpu_irq}, 8'd0);
    line_mask[0] = 1'b0; cyc(1);
    check("R10 unmask", {7'd0, cpu_irq}, 8'd1);
    mst_base = 8'h47;
    do_ack(8'h40, "R7 R10 primary line 0");
    eoi(1'b0);
    cyc(2);
    check("R2 queue drained", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule